// File: doc/BRIEF.md
# Stack Frame Sequencer

This block owns the processor stack pointer and moves processor state between the register file and a byte-wide memory. It handles four frame operations. A subroutine call saves a return address. Interrupt entry saves the whole register set, loads the program counter from a vector and sets the interrupt mask. The two return operations restore what was saved. A fifth command puts the pointer back at the top of the stack. Instruction decode and arithmetic sit outside the block. The decoder presents the register values and pulses one command strobe. The block then runs the memory accesses by itself, one per cycle, and drives the restored register values together with a one-cycle completion pulse.

The stack is 64 bytes, from $00C0 up to $00FF. Only the low six bits of the pointer change; the upper ten bits are constant. A push writes at the pointer and then moves it down. A pull moves the pointer up and then reads. Both moves wrap silently at the ends of the window. Memory reads are combinational: read data belongs to the address presented in the same cycle.

Top module: `stack_frame_unit`

## Requirements
- R1: After reset, sp_o is $00FF, pc_o, x_o, a_o and ccr_o are zero, and busy_o and done_o are low.
- R2: Bits 15..6 of sp_o are always 0000000011. Every stack write and every stack pull addresses memory inside $00C0..$00FF.
- R3: A push writes the byte at sp_o and then decrements the pointer. A push at $00C0 leaves the pointer at $00FF.
- R4: A pull first increments the pointer and then reads at the new value. A pull at $00FF reads $00C0 and leaves the pointer there.
- R5: A call writes PC[7:0] at the pointer and then PC[15:8], so the pointer drops by two. pc_o is unchanged.
- R6: Interrupt entry pushes PC[7:0], PC[15:8], X, A and the flag byte, in that order. It then reads the vector high byte at vec_addr_i and the low byte at vec_addr_i+1 into pc_o. ccr_o becomes the saved flag byte with bit 3 (the interrupt mask) set. x_o and a_o are unchanged.
- R7: Return from subroutine pulls PC[15:8] and then PC[7:0] into pc_o.
- R8: Return from interrupt pulls, in order, the flag byte into ccr_o, then A, then X, then PC[15:8] and PC[7:0].
- R9: The stack-reset command loads $00FF with no memory access. done_o follows one cycle after the command is accepted.
- R10: A command accepted at a clock edge makes its first access in the next cycle and one access per cycle after that. done_o pulses for one cycle right after the last access, so latency is call 3, interrupt 8, subroutine return 3 and interrupt return 6 cycles. No access happens while idle.
- R11: Command strobes that arrive while a sequence is in progress are ignored.
- R12: When several strobes arrive together, one command is accepted. The order, from highest, is interrupt, call, return from interrupt, return from subroutine, stack reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| call_i | input | 1 | Subroutine call strobe |
| irq_i | input | 1 | Interrupt entry strobe |
| rts_i | input | 1 | Return-from-subroutine strobe |
| rti_i | input | 1 | Return-from-interrupt strobe |
| rsp_i | input | 1 | Stack reset strobe |
| pc_i | input | 16 | Program counter to save |
| x_i | input | 8 | Index register to save |
| a_i | input | 8 | Accumulator to save |
| ccr_i | input | 8 | Flag byte to save |
| vec_addr_i | input | 16 | Interrupt vector address (high byte) |
| mem_addr_o | output | 16 | Memory address |
| mem_we_o | output | 1 | Memory write enable |
| mem_re_o | output | 1 | Memory read enable |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, same cycle |
| pc_o | output | 16 | Restored / vectored program counter |
| x_o | output | 8 | Restored index register |
| a_o | output | 8 | Restored accumulator |
| ccr_o | output | 8 | Restored flag byte |
| sp_o | output | 16 | Stack pointer |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Each frame operation runs with distinct byte values in every saved register. A swapped push order or pull order therefore shows up as wrong bytes at known addresses, not as a plausible result. Interrupt entry is followed by its return, and a call by its return. This pairing separates a wrong pointer step from a wrong data path. Thirty-two nested calls drive the pointer through the bottom of the window, and the return that follows crosses the top. These two runs expose wrap and off-by-one pointer faults. Tests that raise several strobes at once, and a strobe raised mid-sequence, tell apart the selection order and the busy lockout.

// File: rtl/sf_pkg.sv
package sf_pkg;
  typedef enum logic [2:0] {OP_NONE, OP_CALL, OP_IRQ, OP_RTS, OP_RTI, OP_RSP} sf_op_e;
  typedef enum logic [2:0] {F_NONE, F_PCL, F_PCH, F_X, F_A, F_CCR} sf_fld_e;

  localparam int unsigned IRQ_PUSHES = 5;

  // number of memory accesses per operation
  function automatic logic [2:0] op_len(sf_op_e op);
    case (op)
      OP_CALL: op_len = 3'd2;
      OP_IRQ:  op_len = 3'd7;
      OP_RTS:  op_len = 3'd2;
      OP_RTI:  op_len = 3'd5;
      default: op_len = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/sf_seq.sv
module sf_seq
  import sf_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    call_i,
  input  logic    irq_i,
  input  logic    rts_i,
  input  logic    rti_i,
  input  logic    rsp_i,
  output sf_op_e  op_o,
  output logic    accept_o,
  output logic    rsp_o,
  output logic    busy_o,
  output logic    done_o,
  output logic    push_o,
  output logic    pull_o,
  output logic    vec_rd_o,
  output logic    vec_lo_o,
  output sf_fld_e fld_o
);
  sf_op_e     op_q, op_sel;
  logic [2:0] step_q, len;
  logic       active;

  // fixed selection order, highest first
  always_comb begin
    if      (irq_i)  op_sel = OP_IRQ;
    else if (call_i) op_sel = OP_CALL;
    else if (rti_i)  op_sel = OP_RTI;
    else if (rts_i)  op_sel = OP_RTS;
    else if (rsp_i)  op_sel = OP_RSP;
    else             op_sel = OP_NONE;
  end

  assign len      = op_len(op_q);
  assign busy_o   = (op_q != OP_NONE);
  assign accept_o = !busy_o && (op_sel != OP_NONE);
  assign rsp_o    = accept_o && (op_sel == OP_RSP);
  assign done_o   = busy_o && (step_q == len);
  assign active   = busy_o && (step_q < len);
  assign op_o     = op_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_NONE;
      step_q <= '0;
    end else if (accept_o) begin
      op_q   <= op_sel;
      step_q <= '0;
    end else if (busy_o) begin
      if (step_q == len) begin
        op_q   <= OP_NONE;
        step_q <= '0;
      end else begin
        step_q <= step_q + 3'd1;
      end
    end
  end

  assign push_o   = active && ((op_q == OP_CALL) ||
                               ((op_q == OP_IRQ) && (step_q < 3'(IRQ_PUSHES))));
  assign pull_o   = active && ((op_q == OP_RTS) || (op_q == OP_RTI));
  assign vec_rd_o = active && (op_q == OP_IRQ) && (step_q >= 3'(IRQ_PUSHES));
  assign vec_lo_o = (step_q == 3'(IRQ_PUSHES + 1));

  always_comb begin
    fld_o = F_NONE;
    if (active) begin
      case (op_q)
        OP_CALL: fld_o = (step_q == 3'd0) ? F_PCL : F_PCH;
        OP_IRQ: begin
          case (step_q)
            3'd0:    fld_o = F_PCL;
            3'd1:    fld_o = F_PCH;
            3'd2:    fld_o = F_X;
            3'd3:    fld_o = F_A;
            3'd4:    fld_o = F_CCR;
            3'd5:    fld_o = F_PCH;
            default: fld_o = F_PCL;
          endcase
        end
        OP_RTS: fld_o = (step_q == 3'd0) ? F_PCH : F_PCL;
        OP_RTI: begin
          case (step_q)
            3'd0:    fld_o = F_CCR;
            3'd1:    fld_o = F_A;
            3'd2:    fld_o = F_X;
            3'd3:    fld_o = F_PCH;
            default: fld_o = F_PCL;
          endcase
        end
        default: fld_o = F_NONE;
      endcase
    end
  end

  p_done_gap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_ignore_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> (op_q == $past(op_q)));
  p_one_dir_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_o && (pull_o || vec_rd_o)));
endmodule

// File: rtl/sf_sp.sv
module sf_sp #(
  parameter int unsigned SP_W   = 6,
  parameter logic [15:0] SP_TOP = 16'h00FF
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rsp_i,
  input  logic        push_i,
  input  logic        pull_i,
  output logic [15:0] sp_o,
  output logic [15:0] pull_addr_o
);
  localparam logic [15-SP_W:0] FIX_BITS = SP_TOP[15:SP_W];
  localparam logic [SP_W-1:0]  PTR_RST  = SP_TOP[SP_W-1:0];

  logic [SP_W-1:0] ptr_q, ptr_inc;

  assign ptr_inc     = ptr_q + 1'b1;
  assign sp_o        = {FIX_BITS, ptr_q};
  assign pull_addr_o = {FIX_BITS, ptr_inc};

  // wrap at the window edges is the natural overflow of ptr_q
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= PTR_RST;
    else if (rsp_i)  ptr_q <= PTR_RST;
    else if (push_i) ptr_q <= ptr_q - 1'b1;
    else if (pull_i) ptr_q <= ptr_inc;
  end

  p_push_dec_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> (ptr_q == $past(ptr_q) - 1'b1));
  p_pull_inc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_i |=> (ptr_q == $past(ptr_q) + 1'b1));
  p_rsp_top_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_i |=> (ptr_q == PTR_RST));
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rsp_i && !push_i && !pull_i) |=> $stable(ptr_q));
endmodule

// File: rtl/sf_regs.sv
module sf_regs
  import sf_pkg::*;
#(
  parameter int unsigned I_BIT = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        accept_i,
  input  logic [15:0] pc_i,
  input  logic [7:0]  x_i,
  input  logic [7:0]  a_i,
  input  logic [7:0]  ccr_i,
  input  logic [15:0] vec_addr_i,
  input  sf_fld_e     fld_i,
  input  logic        push_i,
  input  logic        load_i,
  input  logic        vec_lo_i,
  input  logic [7:0]  rdata_i,
  output logic [7:0]  wdata_o,
  output logic [15:0] vec_addr_o,
  output logic [15:0] pc_o,
  output logic [7:0]  x_o,
  output logic [7:0]  a_o,
  output logic [7:0]  ccr_o
);
  localparam logic [7:0] I_MASK = 8'(1 << I_BIT);

  logic [15:0] snap_pc, snap_vec;
  logic [7:0]  snap_x, snap_a, snap_ccr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_pc  <= '0;
      snap_vec <= '0;
      snap_x   <= '0;
      snap_a   <= '0;
      snap_ccr <= '0;
    end else if (accept_i) begin
      snap_pc  <= pc_i;
      snap_vec <= vec_addr_i;
      snap_x   <= x_i;
      snap_a   <= a_i;
      snap_ccr <= ccr_i;
    end
  end

  always_comb begin
    case (fld_i)
      F_PCL:   wdata_o = snap_pc[7:0];
      F_PCH:   wdata_o = snap_pc[15:8];
      F_X:     wdata_o = snap_x;
      F_A:     wdata_o = snap_a;
      F_CCR:   wdata_o = snap_ccr;
      default: wdata_o = '0;
    endcase
  end

  assign vec_addr_o = snap_vec + {15'd0, vec_lo_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o  <= '0;
      x_o   <= '0;
      a_o   <= '0;
      ccr_o <= '0;
    end else if (load_i) begin
      case (fld_i)
        F_PCL:   pc_o[7:0]  <= rdata_i;
        F_PCH:   pc_o[15:8] <= rdata_i;
        F_X:     x_o        <= rdata_i;
        F_A:     a_o        <= rdata_i;
        F_CCR:   ccr_o      <= rdata_i;
        default: ;
      endcase
    end else if (push_i && (fld_i == F_CCR)) begin
      // only interrupt entry pushes the flag byte
      ccr_o <= snap_ccr | I_MASK;
    end
  end

  p_snap_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> $stable(snap_pc) && $stable(snap_ccr));
endmodule

// File: rtl/stack_frame_unit.sv
module stack_frame_unit
  import sf_pkg::*;
#(
  parameter int unsigned SP_W   = 6,
  parameter logic [15:0] SP_TOP = 16'h00FF,
  parameter int unsigned I_BIT  = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        call_i,
  input  logic        irq_i,
  input  logic        rts_i,
  input  logic        rti_i,
  input  logic        rsp_i,
  input  logic [15:0] pc_i,
  input  logic [7:0]  x_i,
  input  logic [7:0]  a_i,
  input  logic [7:0]  ccr_i,
  input  logic [15:0] vec_addr_i,
  output logic [15:0] mem_addr_o,
  output logic        mem_we_o,
  output logic        mem_re_o,
  output logic [7:0]  mem_wdata_o,
  input  logic [7:0]  mem_rdata_i,
  output logic [15:0] pc_o,
  output logic [7:0]  x_o,
  output logic [7:0]  a_o,
  output logic [7:0]  ccr_o,
  output logic [15:0] sp_o,
  output logic        busy_o,
  output logic        done_o
);
  sf_op_e      op;
  sf_fld_e     fld;
  logic        accept, rsp_go, push, pull, vec_rd, vec_lo;
  logic [15:0] pull_addr, vec_addr;

  sf_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .call_i   (call_i),
    .irq_i    (irq_i),
    .rts_i    (rts_i),
    .rti_i    (rti_i),
    .rsp_i    (rsp_i),
    .op_o     (op),
    .accept_o (accept),
    .rsp_o    (rsp_go),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .push_o   (push),
    .pull_o   (pull),
    .vec_rd_o (vec_rd),
    .vec_lo_o (vec_lo),
    .fld_o    (fld)
  );

  sf_sp #(.SP_W(SP_W), .SP_TOP(SP_TOP)) u_sp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rsp_i       (rsp_go),
    .push_i      (push),
    .pull_i      (pull),
    .sp_o        (sp_o),
    .pull_addr_o (pull_addr)
  );

  sf_regs #(.I_BIT(I_BIT)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .pc_i       (pc_i),
    .x_i        (x_i),
    .a_i        (a_i),
    .ccr_i      (ccr_i),
    .vec_addr_i (vec_addr_i),
    .fld_i      (fld),
    .push_i     (push),
    .load_i     (pull || vec_rd),
    .vec_lo_i   (vec_lo),
    .rdata_i    (mem_rdata_i),
    .wdata_o    (mem_wdata_o),
    .vec_addr_o (vec_addr),
    .pc_o       (pc_o),
    .x_o        (x_o),
    .a_o        (a_o),
    .ccr_o      (ccr_o)
  );

  always_comb begin
    if (push)      mem_addr_o = sp_o;
    else if (pull) mem_addr_o = pull_addr;
    else           mem_addr_o = vec_addr;
  end
  assign mem_we_o = push;
  assign mem_re_o = pull || vec_rd;

  p_stack_window_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o || pull) |-> (mem_addr_o[15:SP_W] == SP_TOP[15:SP_W]));
  p_irq_mask_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (op == OP_IRQ)) |-> ccr_o[I_BIT]);
  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_we_o && !mem_re_o));
  p_rsp_silent_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_RSP) |-> (!mem_we_o && !mem_re_o));
endmodule

// File: tb/sim_stack_frame_unit.sv
module sim_stack_frame_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  stb = '0;   // {irq, call, rti, rts, rsp}
  logic [15:0] pc_in = '0;
  logic [7:0]  x_in = '0, a_in = '0, ccr_in = '0;
  logic [15:0] mem_addr, pc_out, sp_out;
  logic        mem_we, mem_re, busy, done;
  logic [7:0]  mem_wdata, mem_rdata, x_out, a_out, ccr_out;

  localparam logic [4:0] S_IRQ = 5'b10000, S_CALL = 5'b01000, S_RTI = 5'b00100,
                         S_RTS = 5'b00010, S_RSP = 5'b00001;
  localparam logic [15:0] VEC = 16'h03FA;

  int checks = 0, errors = 0, cycles = 0;
  int wr_n = 0, rd_n = 0, dn_n = 0;
  logic [15:0] wr_a [0:15];
  logic [7:0]  wr_d [0:15];
  logic [15:0] rd_a [0:15];
  logic [7:0]  mem [0:1023];

  always #5 clk = ~clk;

  stack_frame_unit u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .call_i(stb[3]), .irq_i(stb[4]), .rts_i(stb[1]), .rti_i(stb[2]), .rsp_i(stb[0]),
    .pc_i(pc_in), .x_i(x_in), .a_i(a_in), .ccr_i(ccr_in), .vec_addr_i(VEC),
    .mem_addr_o(mem_addr), .mem_we_o(mem_we), .mem_re_o(mem_re),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .pc_o(pc_out), .x_o(x_out), .a_o(a_out), .ccr_o(ccr_out),
    .sp_o(sp_out), .busy_o(busy), .done_o(done)
  );

  always @(posedge clk) if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
  assign mem_rdata = (mem_addr == VEC) ? 8'h12 :
                     (mem_addr == VEC + 16'd1) ? 8'h34 : mem[mem_addr[9:0]];

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) begin
        if (wr_n < 16) begin wr_a[wr_n] = mem_addr; wr_d[wr_n] = mem_wdata; end
        wr_n++;
      end
      if (mem_re) begin
        if (rd_n < 16) rd_a[rd_n] = mem_addr;
        rd_n++;
      end
      if (done) dn_n++;
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: act %0d cycles exp < 100000", cycles);
      summary();
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act %h exp %h", req, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [4:0] s, output int lat);
    @(negedge clk);
    wr_n = 0; rd_n = 0; dn_n = 0;
    stb = s;
    @(negedge clk);
    stb = '0;
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic t_reset();
    check("R1 sp", 32'(sp_out), 32'h00FF);
    check("R1 pc", 32'(pc_out), 32'h0);
    check("R1 x/a/ccr", {8'h0, x_out, a_out, ccr_out}, 32'h0);
    check("R1 busy/done", {busy, done}, 32'h0);
  endtask

  task automatic t_call();
    int lat;
    pc_in = 16'hA55A;
    run_cmd(S_CALL, lat);
    check("R10 call latency", 32'(lat), 32'd3);
    check("R5 write count", 32'(wr_n), 32'd2);
    check("R5 R3 first push", {wr_a[0], 8'h0, wr_d[0]}, {16'h00FF, 8'h0, 8'h5A});
    check("R5 R3 second push", {wr_a[1], 8'h0, wr_d[1]}, {16'h00FE, 8'h0, 8'hA5});
    check("R3 sp after call", 32'(sp_out), 32'h00FD);
    check("R5 pc_o unchanged", 32'(pc_out), 32'h0);
  endtask

  task automatic t_irq();
    int lat;
    pc_in = 16'h1357; x_in = 8'h22; a_in = 8'h33; ccr_in = 8'hE1;
    run_cmd(S_IRQ, lat);
    check("R10 irq latency", 32'(lat), 32'd8);
    check("R6 write count", 32'(wr_n), 32'd5);
    check("R6 push PCL", {wr_a[0], 8'h0, wr_d[0]}, {16'h00FD, 8'h0, 8'h57});
    check("R6 push PCH", {wr_a[1], 8'h0, wr_d[1]}, {16'h00FC, 8'h0, 8'h13});
    check("R6 push X",   {wr_a[2], 8'h0, wr_d[2]}, {16'h00FB, 8'h0, 8'h22});
    check("R6 push A",   {wr_a[3], 8'h0, wr_d[3]}, {16'h00FA, 8'h0, 8'h33});
    check("R6 push CCR", {wr_a[4], 8'h0, wr_d[4]}, {16'h00F9, 8'h0, 8'hE1});
    check("R6 vector reads", {rd_a[0], rd_a[1]}, {VEC, VEC + 16'd1});
    check("R6 vectored pc", 32'(pc_out), 32'h1234);
    check("R6 mask set", 32'(ccr_out), 32'hE9);
    check("R6 x/a unchanged", {16'h0, x_out, a_out}, 32'h0);
    check("R3 sp after irq", 32'(sp_out), 32'h00F8);
  endtask

  task automatic t_rti();
    int lat;
    pc_in = 16'hFFFF; x_in = 8'hFF; a_in = 8'hFF; ccr_in = 8'hFF;
    run_cmd(S_RTI, lat);
    check("R10 rti latency", 32'(lat), 32'd6);
    check("R8 no writes, 5 reads", {wr_n[15:0], rd_n[15:0]}, {16'd0, 16'd5});
    check("R8 R4 pull order", {rd_a[0], rd_a[4]}, {16'h00F9, 16'h00FD});
    check("R8 ccr/a/x", {8'h0, ccr_out, a_out, x_out}, {8'h0, 8'hE1, 8'h33, 8'h22});
    check("R8 pc", 32'(pc_out), 32'h1357);
    check("R4 sp after rti", 32'(sp_out), 32'h00FD);
  endtask

  task automatic t_rts();
    int lat;
    run_cmd(S_RTS, lat);
    check("R10 rts latency", 32'(lat), 32'd3);
    check("R7 pulls", {rd_a[0], rd_a[1]}, {16'h00FE, 16'h00FF});
    check("R7 pc", 32'(pc_out), 32'hA55A);
    check("R4 sp after rts", 32'(sp_out), 32'h00FF);
  endtask

  task automatic t_busy_ignore();
    @(negedge clk);
    wr_n = 0; rd_n = 0; dn_n = 0;
    pc_in = 16'h0102;
    stb = S_CALL;
    @(negedge clk);
    stb = S_IRQ | S_RSP;
    @(negedge clk);
    stb = '0;
    repeat (6) @(negedge clk);
    check("R11 writes", 32'(wr_n), 32'd2);
    check("R11 one done", 32'(dn_n), 32'd1);
    check("R11 sp", 32'(sp_out), 32'h00FD);
    check("R11 idle after", {busy, mem_we, mem_re}, 32'h0);
  endtask

  task automatic t_rsp();
    int lat;
    run_cmd(S_RSP, lat);
    check("R9 latency", 32'(lat), 32'd1);
    check("R9 sp", 32'(sp_out), 32'h00FF);
    check("R9 no access", {wr_n[15:0], rd_n[15:0]}, 32'h0);
  endtask

  task automatic t_wrap();
    int lat;
    for (int i = 0; i < 31; i++) begin
      pc_in = 16'(i);
      run_cmd(S_CALL, lat);
    end
    check("R3 sp after 62 pushes", 32'(sp_out), 32'h00C1);
    check("R2 fixed bits", 32'(sp_out[15:6]), 32'h003);
    pc_in = 16'hBEEF;
    run_cmd(S_CALL, lat);
    check("R3 wrap pushes", {wr_a[0], wr_a[1]}, {16'h00C1, 16'h00C0});
    check("R3 wrap sp", 32'(sp_out), 32'h00FF);
    run_cmd(S_RTS, lat);
    check("R4 wrap pulls", {rd_a[0], rd_a[1]}, {16'h00C0, 16'h00C1});
    check("R4 wrap pc", 32'(pc_out), 32'hBEEF);
    check("R4 wrap sp", 32'(sp_out), 32'h00C1);
  endtask

  task automatic t_priority();
    int lat;
    run_cmd(S_RSP, lat);
    run_cmd(S_IRQ | S_CALL | S_RTS, lat);
    check("R12 irq over call", {wr_n[15:0], pc_out}, {16'd5, 16'h1234});
    run_cmd(S_RSP, lat);
    run_cmd(S_CALL | S_RTI | S_RTS, lat);
    check("R12 call over returns", {wr_n[15:0], rd_n[15:0]}, {16'd2, 16'd0});
    run_cmd(S_RSP, lat);
    run_cmd(S_RTI | S_RTS | S_RSP, lat);
    check("R12 rti over rts", {rd_n[15:0], sp_out}, {16'd5, 16'h00C4});
    run_cmd(S_RSP, lat);
    run_cmd(S_RTS | S_RSP, lat);
    check("R12 rts over rsp", {rd_n[15:0], sp_out}, {16'd2, 16'h00C1});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_call();
    t_irq();
    t_rti();
    t_rts();
    t_busy_ignore();
    t_rsp();
    t_wrap();
    t_priority();
    summary();
  end
endmodule